// File: doc/BRIEF.md
# Far-End Receiver Detection Sequencer

This block runs the transmit-side handshake that probes whether a receiver is attached at the far end of a serial lane. A host raises a detect request while the lane's power-down control sits at the detect code (2'b10). The sequencer then asserts its charge output and counts clock cycles. During that time it watches a digital comparator input that goes high once the line voltage passes the detect threshold.

A line that rises quickly has no termination load, so the receiver is reported absent. A line that rises slowly, or does not cross at all within the long window, is reported present. The outcome is returned through a status strobe that lasts exactly one cycle and a 3-bit result code. The code is only non-zero on that strobe cycle. The request must then be withdrawn before the block can run again. If the request is withdrawn while the line is still charging, the attempt is abandoned without any report.

There are four states. `ST_IDLE` waits for a request. `ST_CHARGE` times the rise. `ST_REPORT` is the single strobe cycle. `ST_HOLD` waits for the request to drop. The transitions are:
- IDLE→CHARGE: request high and power-down is 2'b10.
- IDLE→HOLD: request high and power-down is any other code.
- CHARGE→IDLE: request low (abort).
- CHARGE→REPORT: comparator high, or the timer reaches its last cycle.
- REPORT→HOLD: request still high.
- REPORT→IDLE: request already low.
- HOLD→IDLE: request low.

Top module: `rxdet_seq`

## Requirements
- R1: After reset, `charge_on` is 0, `stat_vld` is 0 and `stat_code` is 3'b000.
- R2: A request (`det_req`=1) sampled in idle while `pd_mode` is 2'b10 makes `charge_on` high from the next cycle. That first charge cycle is cycle index 0.
- R3: A request sampled in idle while `pd_mode` is not 2'b10 is ignored. No charge and no strobe follow, even if `pd_mode` later changes to 2'b10, until `det_req` has been low for at least one cycle.
- R4: If `cmp_hi` is first sampled high in charge cycle c with c < FAST_CYC, the result code is 3'b000 (receiver absent).
- R5: If `cmp_hi` is first sampled high in charge cycle c with FAST_CYC ≤ c ≤ SLOW_CYC-1, the result code is 3'b011 (receiver present).
- R6: If `cmp_hi` stays low through charge cycle SLOW_CYC-1, the result code is 3'b011. The strobe then falls in cycle SLOW_CYC.
- R7: `stat_vld` is high for exactly one cycle per completed detection, in the cycle after the deciding sample (cycle min(c, SLOW_CYC-1)+1). `charge_on` is low in that cycle.
- R8: `stat_code` reads 3'b000 in every cycle in which `stat_vld` is low.
- R9: After the strobe, while `det_req` stays high, no new detection begins (`charge_on` stays 0 and no strobe).
- R10: If `det_req` is sampled low in any charge cycle, the block returns to idle without a strobe. This holds even if `cmp_hi` rises in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_mode | input | 2 | Lane power-down control; 2'b10 permits detection |
| det_req | input | 1 | Detect request from the host, level held through the handshake |
| cmp_hi | input | 1 | Comparator output, high once the line crosses the detect threshold |
| charge_on | output | 1 | High while the line is charging and the rise is being timed |
| stat_vld | output | 1 | One-cycle strobe marking a completed detection |
| stat_code | output | 3 | Result on the strobe cycle (3'b011 present, 3'b000 absent), 3'b000 otherwise |

## Verification
Two events can land on the same charge cycle. The first pair is a comparator crossing and a request withdrawal. The bench drops `det_req` in exactly the cycle where `cmp_hi` first reads high, and expects no strobe at all, because the abort takes priority. The second pair is a crossing and the long-window expiry. The bench raises `cmp_hi` in cycle SLOW_CYC-1 and expects a single present report in cycle SLOW_CYC, with no second strobe. Random trials also pick the crossing cycle and the abort cycle independently, so both collisions recur with other offsets.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHARGE = 2'd1,
        ST_REPORT = 2'd2,
        ST_HOLD   = 2'd3
    } rxdet_state_e;

    localparam logic [1:0] PD_DETECT   = 2'b10;
    localparam logic [2:0] CODE_ABSENT = 3'b000;
    localparam logic [2:0] CODE_PRESENT = 3'b011;
    localparam logic [2:0] CODE_NONE   = 3'b000;

endpackage

// File: rtl/rxdet_timer.sv
module rxdet_timer #(
    parameter int SLOW_CYC = 600,
    localparam int CW = $clog2(SLOW_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [CW-1:0] cnt,
    output logic          at_last
);

    localparam logic [CW-1:0] LAST = CW'(SLOW_CYC - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_last = run && (cnt == LAST);

    // R6: the count never passes the long window
    a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/rxdet_classify.sv
module rxdet_classify
    import rxdet_pkg::*;
#(
    parameter int FAST_CYC = 18,
    parameter int SLOW_CYC = 600,
    localparam int CW = $clog2(SLOW_CYC + 1)
) (
    input  logic [CW-1:0] cnt,
    input  logic          crossed,
    output logic [2:0]    verdict
);

    localparam logic [CW-1:0] FAST_LIM = CW'(FAST_CYC);

    always_comb begin
        if (crossed && (cnt < FAST_LIM)) begin
            verdict = CODE_ABSENT;
        end else begin
            verdict = CODE_PRESENT;
        end
    end

endmodule

// File: rtl/rxdet_seq.sv
module rxdet_seq
    import rxdet_pkg::*;
#(
    parameter int FAST_CYC = 18,
    parameter int SLOW_CYC = 600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pd_mode,
    input  logic       det_req,
    input  logic       cmp_hi,
    output logic       charge_on,
    output logic       stat_vld,
    output logic [2:0] stat_code
);

    localparam int CW = $clog2(SLOW_CYC + 1);

    rxdet_state_e state_q, state_d;
    logic [2:0]    result_q;
    logic [2:0]    verdict;
    logic [CW-1:0] cnt;
    logic          at_last;
    logic          in_charge;

    assign in_charge = (state_q == ST_CHARGE);

    rxdet_timer #(.SLOW_CYC(SLOW_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_charge),
        .cnt     (cnt),
        .at_last (at_last)
    );

    rxdet_classify #(.FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC)) u_class (
        .cnt     (cnt),
        .crossed (cmp_hi),
        .verdict (verdict)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (det_req) begin
                    state_d = (pd_mode == PD_DETECT) ? ST_CHARGE : ST_HOLD;
                end
            end
            ST_CHARGE: begin
                if (!det_req) begin
                    state_d = ST_IDLE;
                end else if (cmp_hi || at_last) begin
                    state_d = ST_REPORT;
                end
            end
            ST_REPORT: begin
                state_d = det_req ? ST_HOLD : ST_IDLE;
            end
            ST_HOLD: begin
                if (!det_req) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and result latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            result_q <= CODE_NONE;
        end else begin
            state_q <= state_d;
            if (in_charge && det_req && (cmp_hi || at_last)) begin
                result_q <= verdict;
            end
        end
    end

    // outputs
    always_comb begin
        charge_on = 1'b0;
        stat_vld  = 1'b0;
        stat_code = CODE_NONE;
        unique case (state_q)
            ST_IDLE:   ;
            ST_CHARGE: charge_on = 1'b1;
            ST_REPORT: begin
                stat_vld  = 1'b1;
                stat_code = result_q;
            end
            ST_HOLD:   ;
            default:   ;
        endcase
    end

    // R2: charging only starts from a request seen in the detect power-down code
    a_r2_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(charge_on) |-> $past(det_req && pd_mode == PD_DETECT));

    // R7: the strobe lasts one cycle
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |=> !stat_vld);

    // R7: charging and the strobe never overlap
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_vld && charge_on));

    // R4 R5: only the two legal result codes appear on the strobe
    a_r5_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> (stat_code == CODE_ABSENT || stat_code == CODE_PRESENT));

    // R9: no re-arm directly after a report
    a_r9_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |=> !charge_on);

    // R10: a withdrawn request during charge aborts silently
    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (charge_on && !det_req) |=> (!charge_on && !stat_vld));

endmodule

// File: tb/tb_rxdet_seq.sv
`timescale 1ns/1ps
module tb_rxdet_seq;

    localparam int FAST = 18;
    localparam int SLOW = 600;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pd_mode = 2'b00;
    logic       det_req = 1'b0;
    logic       cmp_hi = 1'b0;
    logic       charge_on, stat_vld;
    logic [2:0] stat_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rxdet_seq #(.FAST_CYC(FAST), .SLOW_CYC(SLOW)) dut (
        .clk(clk), .rst_n(rst_n), .pd_mode(pd_mode), .det_req(det_req),
        .cmp_hi(cmp_hi), .charge_on(charge_on), .stat_vld(stat_vld),
        .stat_code(stat_code)
    );

    function automatic logic [2:0] exp_code(int d);
        return (d < FAST) ? 3'b000 : 3'b011;
    endfunction

    function automatic int exp_time(int d);
        return ((d < SLOW - 1) ? d : SLOW - 1) + 1;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        det_req = 1'b0;
        cmp_hi  = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // crossing at charge cycle d; request drops at cycle ab (ab<0: never)
    task automatic run_detect(int d, int ab, string tag);
        int t = exp_time(d);
        bit expect_strobe = !(ab >= 0 && ab < t);
        int seen = 0, seen_at = -1, bad_code = 0, rearm = 0, chg0 = 0;
        logic [2:0] got = 3'b111;
        @(negedge clk);
        pd_mode = 2'b10;
        det_req = 1'b1;
        cmp_hi  = 1'b0;
        for (int i = 0; i < SLOW + 4; i++) begin
            @(negedge clk);
            if (i == 0) chg0 = charge_on;
            if (stat_vld) begin
                seen++;
                seen_at = i;
                got = stat_code;
            end else if (stat_code != 3'b000) begin
                bad_code++;
            end
            if (i > t && charge_on) rearm++;
            cmp_hi  = (i >= d);
            det_req = !(ab >= 0 && i >= ab);
        end
        check(chg0 == 1, {tag, " R2 charge in cycle 0"}, chg0, 1);
        check(bad_code == 0, {tag, " R8 code when no strobe"}, bad_code, 0);
        if (expect_strobe) begin
            check(seen == 1, {tag, " R7 strobe count"}, seen, 1);
            check(seen_at == t, {tag, " R7 strobe cycle"}, seen_at, t);
            check(got == exp_code(d),
                  {tag, (d < FAST) ? " R4 code" : ((d < SLOW) ? " R5 code" : " R6 code")},
                  got, exp_code(d));
            if (ab < 0) check(rearm == 0, {tag, " R9 no rearm"}, rearm, 0);
        end else begin
            check(seen == 0, {tag, " R10 abort no strobe"}, seen, 0);
        end
        go_idle();
    endtask

    task automatic run_ignored(logic [1:0] pd, string tag);
        int hits = 0;
        @(negedge clk);
        pd_mode = pd;
        det_req = 1'b1;
        cmp_hi  = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (charge_on || stat_vld) hits++;
            if (i == 10) pd_mode = 2'b10;
            if (i == 20) cmp_hi = 1'b1;
        end
        check(hits == 0, {tag, " R3 ignored request"}, hits, 0);
        go_idle();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        check(!charge_on && !stat_vld && stat_code == 3'b000, "R1 reset",
              {charge_on, stat_vld, stat_code}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!charge_on && !stat_vld && stat_code == 3'b000, "R1 after release",
              {charge_on, stat_vld, stat_code}, 0);

        run_detect(0,        -1, "dir d0");
        run_detect(FAST - 1, -1, "dir fast edge");
        run_detect(FAST,     -1, "dir fast+0");
        run_detect(SLOW - 1, -1, "dir slow edge");
        run_detect(SLOW + 5, -1, "dir timeout");
        run_detect(40,       40, "dir abort same cycle");
        run_detect(SLOW + 5, 100, "dir abort mid");
        run_detect(40,       41, "dir drop after sample");
        run_ignored(2'b00, "pd00");
        run_ignored(2'b01, "pd01");
        run_ignored(2'b11, "pd11");

        for (int k = 0; k < 40; k++) begin
            int d  = $urandom_range(0, SLOW + 10);
            int ab = ($urandom_range(0, 3) == 0) ? $urandom_range(0, SLOW + 2) : -1;
            if ($urandom_range(0, 7) == 0) run_ignored(2'($urandom_range(0, 2) == 0 ? 0 :
                                                   ($urandom_range(0, 1) ? 1 : 3)), "rnd");
            else run_detect(d, ab, "rnd");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule